// File: doc/BRIEF.md
# Link Bootstrap Loader

This block sits beside a processor core and decides, right after reset, where the core begins executing. When the boot-from-ROM input is high it does no loading at all. It raises its start output with the fixed entry address just below the top of the address space, which is where the reset code lives.

Otherwise the block watches several serial-link receive byte streams, each presented as a valid/ready byte channel. The first link to deliver a byte becomes the boot source for the rest of the load. That first byte is a length count: it gives the number of program bytes that follow on the same link. Each program byte is written into memory through a byte-write port with a ready handshake. The writes go to ascending addresses, starting at a fixed load base placed 18 words above the bottom of the signed 32-bit address space. After the last byte is stored, the block raises start with the load base as the entry address. The start output stays high until the next reset.

Top module: `linkBootLoader`

## Requirements
- R1: With `romBoot` high at reset release, `startValid` rises with `startAddr` = 32'h7FFFFFFE. No memory write is made and no link is made ready.
- R2: When several links present a byte in the same cycle while a source is being chosen, the lowest-numbered one wins. Only that link's `linkReady` bit is raised, so at most one `linkReady` bit is high in any cycle.
- R3: The first byte accepted from the chosen link is an unsigned count N. Exactly N further bytes from that link are written to memory.
- R4: Program byte k (counting from 0) is written at address 32'h80000048 + k, in order of arrival. `linkData` bits [8*i+7:8*i] carry link i's byte.
- R5: Links other than the chosen one are never made ready during the load, and their data never reaches memory.
- R6: A write is presented on `memWrEn`/`memAddr`/`memData` and held stable until `memWrReady` is high at a clock edge. While a write is pending, no link is made ready.
- R7: After the write handshake of the last byte, `startValid` is high from the next cycle on, with `startAddr` = 32'h80000048. From then on no link is made ready and no write is issued.
- R8: A count byte of zero raises `startValid` with `startAddr` = 32'h80000048 in the cycle after it is accepted, with no memory write.
- R9: While reset is active and in the first cycle after it, `startValid` and `memWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| romBoot | input | 1 | Boot from ROM instead of links, sampled after reset |
| linkValid | input | NUM_LINKS | Per-link byte valid |
| linkData | input | 8*NUM_LINKS | Per-link byte, link i in bits [8i+7:8i] |
| linkReady | output | NUM_LINKS | Per-link byte accept |
| memWrEn | output | 1 | Memory byte write request |
| memAddr | output | ADDR_W | Memory byte address |
| memData | output | 8 | Memory byte data |
| memWrReady | input | 1 | Memory accepts the pending write |
| startValid | output | 1 | Core may start executing |
| startAddr | output | ADDR_W | Entry address |

## Verification
The loading path is driven with a three-byte message on a middle link and a two-byte message from one of two links that go valid together. The second case separates lowest-number priority from any other choice, and shows that a still-valid losing link is never accepted. A zero count and the ROM-boot input tell apart the two paths that issue start without a write. A memory that holds back its ready for several cycles shows whether the write is held stable and whether the link stays stalled. Bytes offered after start show whether the finished loader stays inert.

// File: rtl/bootLoaderPkg.sv
package bootLoaderPkg;

  typedef enum logic [2:0] {
    ST_DECIDE,
    ST_ARB,
    ST_FETCH,
    ST_STORE,
    ST_RUN
  } loadState_e;

  typedef struct packed {
    logic takeCount;
    logic takeByte;
    logic stepAddr;
    logic pickRom;
  } ctrlStrobes_t;

endpackage

// File: rtl/bootLoaderCtrl.sv
module bootLoaderCtrl
  import bootLoaderPkg::*;
#(
  parameter int NUM_LINKS = 4,
  localparam int IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 romBoot,
  input  logic [NUM_LINKS-1:0] linkValid,
  input  logic                 winnerByteZero,
  input  logic                 lastByte,
  input  logic                 memWrReady,
  input  logic [IDX_W-1:0]     selIdx,
  output ctrlStrobes_t         strobes,
  output logic [IDX_W-1:0]     winnerIdx,
  output logic [NUM_LINKS-1:0] linkReady,
  output logic                 memWrEn,
  output logic                 startValid
);

  loadState_e state, nextState;
  logic anyValid;

  // lowest-numbered valid link has priority
  always_comb begin
    winnerIdx = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (linkValid[i]) winnerIdx = IDX_W'(i);
    end
  end

  assign anyValid = |linkValid;

  always_comb begin
    nextState = state;
    strobes   = '0;
    linkReady = '0;
    unique case (state)
      ST_DECIDE: begin
        if (romBoot) begin
          strobes.pickRom = 1'b1;
          nextState       = ST_RUN;
        end else begin
          nextState = ST_ARB;
        end
      end
      ST_ARB: begin
        if (anyValid) begin
          linkReady[winnerIdx] = 1'b1;
          strobes.takeCount    = 1'b1;
          nextState            = winnerByteZero ? ST_RUN : ST_FETCH;
        end
      end
      ST_FETCH: begin
        linkReady[selIdx] = 1'b1;
        if (linkValid[selIdx]) begin
          strobes.takeByte = 1'b1;
          nextState        = ST_STORE;
        end
      end
      ST_STORE: begin
        if (memWrReady) begin
          strobes.stepAddr = 1'b1;
          nextState        = lastByte ? ST_RUN : ST_FETCH;
        end
      end
      ST_RUN: nextState = ST_RUN;
      default: nextState = ST_DECIDE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_DECIDE;
    else       state <= nextState;
  end

  assign memWrEn    = (state == ST_STORE);
  assign startValid = (state == ST_RUN);

endmodule

// File: rtl/bootLoaderDatapath.sv
module bootLoaderDatapath
  import bootLoaderPkg::*;
#(
  parameter int          NUM_LINKS  = 4,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] LOAD_BASE  = 32'h8000_0048,
  parameter logic [31:0] ROM_ENTRY  = 32'h7FFF_FFFE,
  localparam int IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int DATA_W = 8 * NUM_LINKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  winnerIdx,
  input  logic [DATA_W-1:0] linkData,
  output logic [IDX_W-1:0]  selIdx,
  output logic              winnerByteZero,
  output logic              lastByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] startAddr
);

  logic [7:0] linkByte [NUM_LINKS];
  logic [7:0] winnerByte, selByte;
  logic [7:0] remaining;
  logic [ADDR_W-1:0] addrReg;
  logic [7:0] dataReg;
  logic romSel;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_split
    assign linkByte[g] = linkData[8*g +: 8];
  end

  assign winnerByte     = linkByte[winnerIdx];
  assign selByte        = linkByte[selIdx];
  assign winnerByteZero = (winnerByte == 8'd0);
  assign lastByte       = (remaining == 8'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx    <= '0;
      remaining <= '0;
      addrReg   <= ADDR_W'(LOAD_BASE);
      dataReg   <= '0;
      romSel    <= 1'b0;
    end else begin
      if (strobes.pickRom) romSel <= 1'b1;
      if (strobes.takeCount) begin
        selIdx    <= winnerIdx;
        remaining <= winnerByte;
      end
      if (strobes.takeByte) dataReg <= selByte;
      if (strobes.stepAddr) begin
        addrReg   <= addrReg + 1'b1;
        remaining <= remaining - 8'd1;
      end
    end
  end

  assign memAddr   = addrReg;
  assign memData   = dataReg;
  assign startAddr = romSel ? ADDR_W'(ROM_ENTRY) : ADDR_W'(LOAD_BASE);

endmodule

// File: rtl/linkBootLoader.sv
module linkBootLoader
  import bootLoaderPkg::*;
#(
  parameter int          NUM_LINKS = 4,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] LOAD_BASE = 32'h8000_0048,
  parameter logic [31:0] ROM_ENTRY = 32'h7FFF_FFFE
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   romBoot,
  input  logic [NUM_LINKS-1:0]   linkValid,
  input  logic [8*NUM_LINKS-1:0] linkData,
  output logic [NUM_LINKS-1:0]   linkReady,
  output logic                   memWrEn,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [7:0]             memData,
  input  logic                   memWrReady,
  output logic                   startValid,
  output logic [ADDR_W-1:0]      startAddr
);

  localparam int IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] winnerIdx, selIdx;
  logic             winnerByteZero, lastByte;

  bootLoaderCtrl #(.NUM_LINKS(NUM_LINKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .romBoot(romBoot), .linkValid(linkValid),
    .winnerByteZero(winnerByteZero), .lastByte(lastByte),
    .memWrReady(memWrReady), .selIdx(selIdx), .strobes(strobes),
    .winnerIdx(winnerIdx), .linkReady(linkReady), .memWrEn(memWrEn),
    .startValid(startValid)
  );

  bootLoaderDatapath #(
    .NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W),
    .LOAD_BASE(LOAD_BASE), .ROM_ENTRY(ROM_ENTRY)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winnerIdx(winnerIdx),
    .linkData(linkData), .selIdx(selIdx), .winnerByteZero(winnerByteZero),
    .lastByte(lastByte), .memAddr(memAddr), .memData(memData),
    .startAddr(startAddr)
  );

endmodule

// File: rtl/linkBootLoaderChecker.sv
module linkBootLoaderChecker #(
  parameter int          NUM_LINKS = 4,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] LOAD_BASE = 32'h8000_0048,
  parameter logic [31:0] ROM_ENTRY = 32'h7FFF_FFFE
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINKS-1:0] linkReady,
  input logic                 memWrEn,
  input logic [ADDR_W-1:0]    memAddr,
  input logic [7:0]           memData,
  input logic                 memWrReady,
  input logic                 startValid,
  input logic [ADDR_W-1:0]    startAddr
);

  // R2
  one_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(linkReady));

  // R6
  hold_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && !memWrReady |=> memWrEn && $stable(memAddr) && $stable(memData));

  // R6
  stall_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> linkReady == '0);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && memWrReady |=> memAddr == $past(memAddr) + 1'b1);

  // R7
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> startValid && $stable(startAddr));

  // R7
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !memWrEn && linkReady == '0);

  // R1
  entry_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> startAddr == ADDR_W'(LOAD_BASE) || startAddr == ADDR_W'(ROM_ENTRY));

endmodule

bind linkBootLoader linkBootLoaderChecker #(
  .NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W),
  .LOAD_BASE(LOAD_BASE), .ROM_ENTRY(ROM_ENTRY)
) i_chk (
  .clk(clk), .rstN(rstN), .linkReady(linkReady), .memWrEn(memWrEn),
  .memAddr(memAddr), .memData(memData), .memWrReady(memWrReady),
  .startValid(startValid), .startAddr(startAddr)
);

// File: tb/test_linkBootLoader.sv
module test_linkBootLoader;

  localparam int NL = 4;
  localparam logic [31:0] BASE = 32'h8000_0048;
  localparam logic [31:0] ROMA = 32'h7FFF_FFFE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic romBoot = 1'b0;
  logic [NL-1:0] linkValid = '0;
  logic [8*NL-1:0] linkData = '0;
  logic [NL-1:0] linkReady;
  logic memWrEn, memWrReady = 1'b1, startValid;
  logic [31:0] memAddr, startAddr;
  logic [7:0] memData;

  int checks = 0, errors = 0, cycles = 0;
  int wCount;
  logic [31:0] wAddr [16];
  logic [7:0]  wData [16];
  int link3Hits;

  always #10 clk = ~clk;

  linkBootLoader i_linkBootLoader (
    .clk(clk), .rstN(rstN), .romBoot(romBoot), .linkValid(linkValid),
    .linkData(linkData), .linkReady(linkReady), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .memWrReady(memWrReady),
    .startValid(startValid), .startAddr(startAddr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      wCount <= 0;
      link3Hits <= 0;
    end else begin
      if (memWrEn && memWrReady && wCount < 16) begin
        wAddr[wCount] <= memAddr;
        wData[wCount] <= memData;
        wCount <= wCount + 1;
      end
      if (linkReady[3]) link3Hits <= link3Hits + 1;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    summary();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic rom);
    @(negedge clk);
    rstN = 1'b0; romBoot = rom; linkValid = '0; memWrReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendByte(input int l, input logic [7:0] d);
    @(negedge clk);
    linkValid[l] = 1'b1;
    linkData[l*8 +: 8] = d;
    #1;
    while (!linkReady[l]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    linkValid[l] = 1'b0;
  endtask

  task automatic waitStart();
    for (int i = 0; i < 50 && !startValid; i++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(startValid == 1'b0, "R9 startValid in reset", 32'(startValid), 0);
    check(memWrEn == 1'b0, "R9 memWrEn in reset", 32'(memWrEn), 0);
    rstN = 1'b1;
    #1;
    check(startValid == 1'b0, "R9 startValid after release", 32'(startValid), 0);
  endtask

  task automatic testRom();
    doReset(1'b1);
    linkValid[0] = 1'b1; linkData[7:0] = 8'h05;
    repeat (3) @(negedge clk);
    check(startValid == 1'b1, "R1 start raised", 32'(startValid), 1);
    check(startAddr == ROMA, "R1 rom entry", startAddr, ROMA);
    check(linkReady == '0, "R1 no link ready", 32'(linkReady), 0);
    check(wCount == 0, "R1 no writes", wCount, 0);
    linkValid = '0;
  endtask

  task automatic testLoad();
    logic [7:0] bytes [3] = '{8'hA1, 8'hB2, 8'hC3};
    doReset(1'b0);
    sendByte(2, 8'd3);
    foreach (bytes[i]) sendByte(2, bytes[i]);
    waitStart();
    check(wCount == 3, "R3 byte count", wCount, 3);
    for (int i = 0; i < 3; i++) begin
      check(wAddr[i] == BASE + i, "R4 address", wAddr[i], BASE + i);
      check(wData[i] == bytes[i], "R4 data order", 32'(wData[i]), 32'(bytes[i]));
    end
    check(startValid && startAddr == BASE, "R7 start at base", startAddr, BASE);
    // R7 bytes after start are ignored
    @(negedge clk);
    linkValid[2] = 1'b1; linkData[23:16] = 8'h77;
    repeat (3) @(negedge clk);
    check(linkReady == '0, "R7 no ready after start", 32'(linkReady), 0);
    check(wCount == 3, "R7 no write after start", wCount, 3);
    linkValid = '0;
  endtask

  task automatic testPriority();
    doReset(1'b0);
    @(negedge clk);
    linkValid[1] = 1'b1; linkData[15:8] = 8'd2;
    linkValid[3] = 1'b1; linkData[31:24] = 8'd9;
    #1;
    check(linkReady == 4'b0010, "R2 lowest link wins", 32'(linkReady), 32'h2);
    @(posedge clk);
    #1;
    linkValid[1] = 1'b0;
    sendByte(1, 8'h11);
    sendByte(1, 8'h22);
    waitStart();
    check(wCount == 2, "R3 count from winner", wCount, 2);
    check(wData[0] == 8'h11 && wData[1] == 8'h22, "R5 only winner data",
          {wData[0], wData[1]}, 32'h1122);
    check(link3Hits == 0, "R5 loser never ready", link3Hits, 0);
    linkValid = '0;
  endtask

  task automatic testZero();
    doReset(1'b0);
    sendByte(0, 8'd0);
    @(negedge clk);
    check(startValid == 1'b1, "R8 immediate start", 32'(startValid), 1);
    check(startAddr == BASE, "R8 entry base", startAddr, BASE);
    check(wCount == 0 && !memWrEn, "R8 no write", wCount, 0);
  endtask

  task automatic testStall();
    logic [31:0] heldAddr;
    doReset(1'b0);
    memWrReady = 1'b0;
    sendByte(0, 8'd2);
    sendByte(0, 8'h5A);
    @(negedge clk);
    heldAddr = memAddr;
    linkValid[0] = 1'b1; linkData[7:0] = 8'h6B;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(memWrEn == 1'b1, "R6 write held", 32'(memWrEn), 1);
      check(memAddr == heldAddr && memData == 8'h5A, "R6 write stable",
            memAddr, heldAddr);
      check(linkReady == '0, "R6 link stalled", 32'(linkReady), 0);
    end
    linkValid[0] = 1'b0;
    memWrReady = 1'b1;
    sendByte(0, 8'h6B);
    waitStart();
    check(wCount == 2 && wData[0] == 8'h5A && wData[1] == 8'h6B,
          "R6 both bytes after stall", wCount, 2);
  endtask

  initial begin
    testReset();
    testRom();
    testLoad();
    testPriority();
    testZero();
    testStall();
    summary();
  end

endmodule